// File: doc/BRIEF.md
# Quasi-Random Pattern Sync Detector

This block checks a received serial stream against a locally regenerated quasi-random test pattern. The pattern comes from a 20-stage shift register whose new bit is the XOR of the bits 20 and 17 positions back. Any output bit that follows 14 consecutive zeros of the raw sequence is forced to 1. The receiver has no fixed seed. It fills its reference register from 20 received bits and then lets it run freely. It compares every following bit with its own prediction.

Errors are counted over 128-bit windows. An unsynchronized receiver locks when a window holds few errors, and a synchronized one unlocks when a window holds many. The gap between the two thresholds gives hysteresis. While locked, the active-low detect output stays low and gives a one-cycle high pulse for every bit error. The logic runs at twice the bit rate, so one cycle is half a bit period, and an edge option selects which half carries the pulse. An external error counter can count these pulses. A status bit, a sticky change flag and a maskable interrupt report acquisition and loss of lock.

Top module: `qrss_sync_det`

## Requirements
- R1: After reset, sync_st is 0, qpd is 1, chg_flag is 0 and irq is 0.
- R2: The reference bit is b(n-20) XOR b(n-17), forced to 1 when the 14 raw bits before it are all 0. A stream that follows this rule, including its forced ones, raises no error while the block is synchronized.
- R3: After 20 seed bits, a 128-bit window with 3 or fewer mismatches sets sync_st to 1. With 4 or more, sync_st stays 0 and 20 new seed bits are taken before the next window. sync_st changes only after a bit_en cycle or a los cycle.
- R4: While sync_st is 1, a window with 5 or more mismatches clears sync_st and the block reseeds. A window with 4 or fewer leaves sync_st at 1.
- R5: qpd is 1 in every cycle after a cycle where sync_st was 0, and it is 0 while synchronized with no error pending.
- R6: Inputs: bit_en is 1 in the cycle where phase is 0, and phase alternates every cycle. Each mismatch while synchronized gives exactly one one-cycle high pulse on qpd in the following bit period. With edge_sel 0 the pulse falls in the cycle where phase is 0, and with edge_sel 1 in the cycle where phase is 1.
- R7: los high drives qpd to 1 and sync_st to 0 from the next cycle, and the block reseeds afterwards.
- R8: chg_flag is set one cycle after every change of sync_st and stays set until chg_clr. When a new change and chg_clr meet, the set wins.
- R9: irq is 1 exactly when chg_flag is set and irq_mask is 0. irq_mask 1 keeps irq at 0 while chg_flag is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Marks the cycle that carries a received bit |
| phase | input | 1 | Half-period marker: 0 first half, 1 second half |
| rx_bit | input | 1 | Received data bit |
| edge_sel | input | 1 | Pulse half select |
| los | input | 1 | Loss of signal |
| irq_mask | input | 1 | 1 blocks the interrupt |
| chg_clr | input | 1 | Clears the change flag |
| qpd | output | 1 | Active-low pattern detect with error pulses |
| sync_st | output | 1 | Synchronization status |
| chg_flag | output | 1 | Sticky status-change flag |
| irq | output | 1 | Interrupt request |

## Verification
A table of windows feeds clean pattern with 0, 2, 3, 4, 5 or 6 inverted bits, starting from both the locked and the unlocked state. Four errors lock on neither side, while three lock and five unlock, so the table separates the hysteresis band from its edges. In each locked window the bench counts the qpd-high half periods with each value of edge_sel. This tells a correct pulse count from a missing or doubled pulse and from a pulse in the wrong half. A stream placed over the longest zero run of the sequence tests the forced ones. Directed tests of loss of signal, clear, mask and reset cover the status and interrupt logic.

// File: rtl/qrss_pkg.sv
package qrss_pkg;
  typedef enum logic {
    HUNT_SEED  = 1'b0,
    HUNT_TRACK = 1'b1
  } hunt_t;
endpackage

// File: rtl/qrss_ref.sv
// Self-seeding reference generator: loads received bits while seeding,
// free-runs the shift register while tracking.
module qrss_ref #(
  parameter int LEN = 20,
  parameter int TAP = 17,
  parameter int JAM = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic load,
  input  logic rx_bit,
  output logic pred
);
  localparam int ZW = $clog2(JAM + 2);
  localparam logic [ZW-1:0] ZMAX = {ZW{1'b1}};

  logic [LEN-1:0] sr;
  logic [ZW-1:0]  zrun;
  logic           raw, nb;

  always_comb begin
    raw  = sr[LEN-1] ^ sr[TAP-1];
    pred = raw | (zrun >= ZW'(JAM));
    nb   = load ? rx_bit : raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      zrun <= '0;
    end else if (step) begin
      sr   <= {sr[LEN-2:0], nb};
      zrun <= nb ? '0 : ((zrun == ZMAX) ? zrun : zrun + 1'b1);
    end
  end
endmodule

// File: rtl/qrss_win.sv
// Seed/track sequencer with windowed error counting and lock hysteresis.
module qrss_win
  import qrss_pkg::*;
#(
  parameter int WIN_LEN    = 128,
  parameter int SEED_LEN   = 20,
  parameter int LOCK_MAX   = 3,
  parameter int UNLOCK_MIN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic los,
  input  logic mismatch,
  output logic seeding,
  output logic locked,
  output logic bit_err
);
  localparam int WW = $clog2(WIN_LEN);
  localparam int SW = $clog2(SEED_LEN);
  localparam int EW = $clog2(UNLOCK_MIN + 1);

  hunt_t         st;
  logic [WW-1:0] win_cnt;
  logic [SW-1:0] seed_cnt;
  logic [EW-1:0] err_cnt, err_sum;

  always_comb begin
    err_sum = (err_cnt == EW'(UNLOCK_MIN)) ? err_cnt : err_cnt + EW'(mismatch);
    seeding = (st == HUNT_SEED);
    bit_err = step & ~los & locked & (st == HUNT_TRACK) & mismatch;
  end

  always_ff @(posedge clk) begin
    if (rst || los) begin
      st       <= HUNT_SEED;
      locked   <= 1'b0;
      win_cnt  <= '0;
      seed_cnt <= '0;
      err_cnt  <= '0;
    end else if (step) begin
      if (st == HUNT_SEED) begin
        if (seed_cnt == SW'(SEED_LEN - 1)) begin
          st       <= HUNT_TRACK;
          seed_cnt <= '0;
          win_cnt  <= '0;
          err_cnt  <= '0;
        end else begin
          seed_cnt <= seed_cnt + 1'b1;
        end
      end else if (win_cnt == WW'(WIN_LEN - 1)) begin
        win_cnt <= '0;
        err_cnt <= '0;
        if (locked) begin
          if (err_sum >= EW'(UNLOCK_MIN)) begin
            locked <= 1'b0;
            st     <= HUNT_SEED;
          end
        end else if (err_sum <= EW'(LOCK_MAX)) begin
          locked <= 1'b1;
        end else begin
          st <= HUNT_SEED;
        end
      end else begin
        win_cnt <= win_cnt + 1'b1;
        err_cnt <= err_sum;
      end
    end
  end
endmodule

// File: rtl/qrss_out.sv
// Detect output with phased error pulses, change flag and interrupt.
module qrss_out (
  input  logic clk,
  input  logic rst,
  input  logic locked,
  input  logic los,
  input  logic bit_err,
  input  logic phase,
  input  logic edge_sel,
  input  logic irq_mask,
  input  logic chg_clr,
  output logic qpd,
  output logic chg_flag,
  output logic irq
);
  logic hold, lk_d, fire, chg_nx;

  always_comb begin
    fire   = hold & (phase != edge_sel);
    chg_nx = (locked != lk_d) | (chg_flag & ~chg_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= 1'b0;
      lk_d     <= 1'b0;
      qpd      <= 1'b1;
      chg_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      hold     <= locked & ~los & (bit_err | (hold & ~fire));
      lk_d     <= locked;
      qpd      <= los | ~locked | fire;
      chg_flag <= chg_nx;
      irq      <= chg_nx & ~irq_mask;
    end
  end
endmodule

// File: rtl/qrss_sync_det.sv
module qrss_sync_det #(
  parameter int LFSR_LEN   = 20,
  parameter int LFSR_TAP   = 17,
  parameter int JAM_RUN    = 14,
  parameter int WIN_LEN    = 128,
  parameter int LOCK_MAX   = 3,
  parameter int UNLOCK_MIN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic phase,
  input  logic rx_bit,
  input  logic edge_sel,
  input  logic los,
  input  logic irq_mask,
  input  logic chg_clr,
  output logic qpd,
  output logic sync_st,
  output logic chg_flag,
  output logic irq
);
  localparam int SEED_LEN = LFSR_LEN;

  logic pred, seeding, locked, bit_err, mismatch;

  qrss_ref #(.LEN(LFSR_LEN), .TAP(LFSR_TAP), .JAM(JAM_RUN)) u_ref (
    .clk(clk), .rst(rst || los), .step(bit_en), .load(seeding),
    .rx_bit(rx_bit), .pred(pred)
  );

  assign mismatch = rx_bit ^ pred;

  qrss_win #(.WIN_LEN(WIN_LEN), .SEED_LEN(SEED_LEN),
             .LOCK_MAX(LOCK_MAX), .UNLOCK_MIN(UNLOCK_MIN)) u_win (
    .clk(clk), .rst(rst), .step(bit_en), .los(los), .mismatch(mismatch),
    .seeding(seeding), .locked(locked), .bit_err(bit_err)
  );

  qrss_out u_out (
    .clk(clk), .rst(rst), .locked(locked), .los(los), .bit_err(bit_err),
    .phase(phase), .edge_sel(edge_sel), .irq_mask(irq_mask),
    .chg_clr(chg_clr), .qpd(qpd), .chg_flag(chg_flag), .irq(irq)
  );

  assign sync_st = locked;
endmodule

// File: rtl/qrss_sync_chk.sv
module qrss_sync_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic phase,
  input logic edge_sel,
  input logic los,
  input logic irq_mask,
  input logic qpd,
  input logic sync_st,
  input logic chg_flag,
  input logic irq
);
  AST_LOS_FORCES_HIGH: assert property (@(posedge clk) disable iff (rst)
    los |=> (qpd && !sync_st)); // R7
  AST_UNSYNC_HIGH: assert property (@(posedge clk) disable iff (rst)
    !sync_st |=> qpd); // R5
  AST_PULSE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (qpd && $past(sync_st) && !$past(los)) |-> (phase == edge_sel)); // R6
  AST_SYNC_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    (sync_st != $past(sync_st)) |-> ($past(bit_en) || $past(los))); // R3
  AST_CHG_ON_FLIP: assert property (@(posedge clk) disable iff (rst)
    (sync_st != $past(sync_st)) |=> chg_flag); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (chg_flag && !$past(irq_mask))); // R9
endmodule

bind qrss_sync_det qrss_sync_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .phase(phase), .edge_sel(edge_sel),
  .los(los), .irq_mask(irq_mask), .qpd(qpd), .sync_st(sync_st),
  .chg_flag(chg_flag), .irq(irq)
);

// File: tb/sim_qrss_sync_det.sv
module sim_qrss_sync_det;
  logic clk = 1'b0;
  logic rst = 1'b1, bit_en = 1'b0, phase = 1'b1, rx_bit = 1'b0;
  logic edge_sel = 1'b0, los = 1'b0, irq_mask = 1'b0, chg_clr = 1'b0;
  logic qpd, sync_st, chg_flag, irq;

  int n_chk = 0, n_err = 0;
  int hi_match = 0, hi_other = 0;
  logic [19:0] g_sr;
  int g_zr;
  logic ex_lk;

  always #10 clk = ~clk;

  qrss_sync_det u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .phase(phase), .rx_bit(rx_bit),
    .edge_sel(edge_sel), .los(los), .irq_mask(irq_mask), .chg_clr(chg_clr),
    .qpd(qpd), .sync_st(sync_st), .chg_flag(chg_flag), .irq(irq)
  );

  // {errors[5:2], edge_sel[1], expected sync after window[0]}
  localparam logic [5:0] ROWS [9] = '{
    {4'd0, 1'b0, 1'b1}, {4'd0, 1'b0, 1'b1}, {4'd4, 1'b1, 1'b1},
    {4'd5, 1'b0, 1'b0}, {4'd4, 1'b0, 1'b0}, {4'd3, 1'b0, 1'b1},
    {4'd2, 1'b1, 1'b1}, {4'd6, 1'b0, 1'b0}, {4'd0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic next_pat(output logic b);
    logic raw;
    raw  = g_sr[19] ^ g_sr[16];
    b    = raw | (g_zr >= 14);
    g_sr = {g_sr[18:0], raw};
    g_zr = raw ? 0 : ((g_zr < 15) ? g_zr + 1 : 15);
  endtask

  task automatic tally(input logic p);
    if (qpd) begin
      if (p == edge_sel) hi_match++;
      else hi_other++;
    end
  endtask

  task automatic send_bit(input logic flip);
    logic b;
    next_pat(b);
    @(negedge clk); tally(1'b0); phase = 1'b0; bit_en = 1'b1; rx_bit = b ^ flip;
    @(negedge clk); tally(1'b1); phase = 1'b1; bit_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tally(~phase); phase = ~phase; bit_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_en = 1'b0; phase = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_gen(input logic [19:0] s);
    g_sr = s;
    g_zr = 0;
    for (int i = 0; i < 15; i++) begin
      if (s[i]) break;
      g_zr++;
    end
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    int nerr;
    logic [19:0] s;
    set_gen(20'h5ACE1);
    do_reset();
    @(negedge clk);
    chk("R1", "sync_st", sync_st, 0);
    chk("R1", "qpd", qpd, 1);
    chk("R1", "chg_flag", chg_flag, 0);
    chk("R1", "irq", irq, 0);

    // table walk: one row per 128-bit window
    ex_lk = 1'b0;
    for (int r = 0; r < 9; r++) begin
      nerr = int'(ROWS[r][5:2]);
      edge_sel = ROWS[r][1];
      if (!ex_lk) for (int k = 0; k < 20; k++) send_bit(1'b0);
      hi_match = 0; hi_other = 0;
      for (int k = 0; k < 128; k++)
        send_bit(k >= 10 && ((k - 10) % 20) == 0 && ((k - 10) / 20) < nerr);
      if (ex_lk) begin
        chk("R4", "sync after locked window", sync_st, int'(ROWS[r][0]));
        chk("R6", "pulse count", hi_match, nerr);
        chk("R6", "pulses in wrong half", hi_other, 0);
        if (nerr == 0) chk("R5", "qpd high while clean", hi_match, 0);
      end else begin
        chk("R3", "sync after hunting window", sync_st, int'(ROWS[r][0]));
      end
      ex_lk = ROWS[r][0];
    end

    // change flag and interrupt
    edge_sel = 1'b0;
    idle(2);
    chk("R8", "chg_flag after lock", chg_flag, 1);
    chk("R9", "irq unmasked", irq, 1);
    @(negedge clk); chg_clr = 1'b1; phase = ~phase;
    @(negedge clk); chg_clr = 1'b0; phase = ~phase;
    idle(1);
    chk("R8", "chg_flag after clear", chg_flag, 0);
    chk("R9", "irq after clear", irq, 0);

    // loss of signal with interrupt masked
    irq_mask = 1'b1;
    @(negedge clk); los = 1'b1; phase = ~phase;
    @(negedge clk); phase = ~phase;
    chk("R7", "qpd under los", qpd, 1);
    chk("R7", "sync_st under los", sync_st, 0);
    idle(1);
    los = 1'b0;
    idle(2);
    chk("R8", "chg_flag after los", chg_flag, 1);
    chk("R9", "irq masked", irq, 0);
    irq_mask = 1'b0;
    idle(2);
    chk("R9", "irq unmasked again", irq, 1);
    @(negedge clk); chg_clr = 1'b1; phase = ~phase;
    @(negedge clk); chg_clr = 1'b0; phase = ~phase;
    for (int k = 0; k < 148; k++) send_bit(1'b0);
    chk("R7", "relock after los", sync_st, 1);
    idle(2);
    chk("R8", "chg_flag after relock", chg_flag, 1);
    chk("R5", "qpd low when locked", qpd, 0);

    // reset mid-run
    do_reset();
    @(negedge clk);
    chk("R1", "sync_st after reset", sync_st, 0);
    chk("R1", "qpd after reset", qpd, 1);
    chk("R1", "chg_flag after reset", chg_flag, 0);

    // forced ones: start 300 bits before the longest zero run
    s = 20'h00001;
    for (int i = 0; i < 300; i++) s = {s[0] ^ s[17], s[19:1]};
    set_gen(s);
    phase = 1'b1;
    for (int k = 0; k < 148; k++) send_bit(1'b0);
    chk("R2", "lock before zero run", sync_st, 1);
    hi_match = 0; hi_other = 0;
    for (int k = 0; k < 256; k++) send_bit(1'b0);
    chk("R2", "sync across forced ones", sync_st, 1);
    chk("R2", "no error pulses across forced ones", hi_match + hi_other, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule